// File: doc/BRIEF.md
# Two-Channel Serial ADC Port Emulator

This block models the digital half of a small sampling converter that has an 8-bit result and a three-wire serial port. A host drives chip select (active low), a shift clock and a serial command line. In the normal two-channel variant the block waits for a start bit on the command line. It then takes three configuration bits, which select single-ended or differential measurement, pick the channel polarity and choose the output bit order. It then captures one sample from a parallel port that stands in for the analog converter and returns that sample on a serial output.

All serial lines are sampled with the block's own system clock, and serial clock edges are found by comparing each sample with the one before. The output is a data bit plus a separate drive enable, which an external pad buffer uses. The decoded channel pair is given as two small channel codes with a valid flag, so a neighbour or a bench can see which inputs would be measured. A build-time option selects a single-input variant that takes no command word.

Top module: `adc_emu`

## Requirements
- R1: While chip select is low and no start has been seen, a 0 sampled at a rising serial clock edge is ignored. The first 1 sampled at a rising edge is the start bit. Until the command is complete, `chan_valid` and `so_oe` stay 0.
- R2: The three rising edges after the start bit take, in this order, the single-ended flag, the odd/sign flag and the MSB-first flag. After that, the command line has no effect on any output until chip select goes high and low again.
- R3: The channel codes are CH0=0, CH1=1, ground=2. single=1,odd=0 gives pos 0, neg 2. single=1,odd=1 gives pos 1, neg 2. single=0,odd=0 gives pos 0, neg 1. single=0,odd=1 gives pos 1, neg 0. `chan_valid` is 1 from the edge that takes the MSB-first flag until chip select rises.
- R4: `so_oe` and `so_data` are 0 while chip select is high. `so_oe` first rises on the falling serial clock edge after the command completes, and never earlier. On that edge `so_data` carries the null bit, which is 0.
- R5: On each later falling edge the output gives one sample bit, B7 first and B0 last.
- R6: If the MSB-first flag is 0, bits B1 up to B7 follow B0. In both orders, 0 is driven on every later falling edge while the clock keeps running.
- R7: The sample is captured from `sample_in` on the rising edge that takes the MSB-first flag. In the single-input variant it is captured on the first rising edge. Later changes of `sample_in` do not change the serial stream.
- R8: Chip select going high aborts a command or a transfer at any point. The outputs drop at once, and the next low period starts a fresh command search.
- R9: With `SINGLE_INPUT`=1 no command is read. The first rising edge after chip select falls completes the setup, and the next falling edge drives the null bit. The stream always carries the LSB-first tail, and the channels are pos 0, neg 1.
- R10: A synchronous active-low reset clears the command state and all outputs, even while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial shift clock from the host |
| din | input | 1 | Serial command line |
| sample_in | input | DATA_W | Parallel sample standing in for the converter |
| so_data | output | 1 | Serial result bit |
| so_oe | output | 1 | Drive enable for the serial result pad |
| chan_pos | output | 2 | Code of the positive input (0, 1, or 2 for ground) |
| chan_neg | output | 2 | Code of the negative input |
| chan_valid | output | 1 | Channel codes are valid for this transfer |

## Verification
The bench builds two instances, both with `DATA_W`=8. One uses `SINGLE_INPUT`=0 and is driven by a table of commands that covers all four channel settings, both bit orders and different counts of leading zeros. The other uses `SINGLE_INPUT`=1, which brings the command-free path and its fixed LSB-first tail within reach. The 8-bit width keeps the stream short, so every frame can run past the saturation slot at position 16 and show the trailing zeros in both orders.

// File: rtl/adc_emu_pkg.sv
// Shared constants and types for the serial ADC port emulator.
// Assumes channel codes fit in two bits: CH0, CH1 and ground.
package adc_emu_pkg;
    localparam logic [1:0] CODE_CH0 = 2'd0;
    localparam logic [1:0] CODE_CH1 = 2'd1;
    localparam logic [1:0] CODE_GND = 2'd2;

    typedef enum logic [1:0] {
        CMD_HUNT  = 2'd0,
        CMD_FIELD = 2'd1,
        CMD_DONE  = 2'd2
    } cmd_state_e;
endpackage

// File: rtl/adc_emu_edge.sv
// Serial clock edge finder. It samples sclk on the system clock and flags
// single-cycle rise and fall events.
// Assumes sclk is already synchronous to clk, or comes through a synchroniser
// outside this block.
module adc_emu_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Purpose: keep last cycle's serial clock level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/adc_emu_cmd.sv
// Command receiver. It hunts for the start bit, takes the three setup bits
// and decodes the channel pair.
// The SINGLE_INPUT variant takes no command and completes on the first rise.
// Assumes rise is a one-cycle pulse and that cs_n high means idle.
module adc_emu_cmd
    import adc_emu_pkg::*;
#(
    parameter bit SINGLE_INPUT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       din,
    input  logic       rise,
    output logic       take,
    output logic       done,
    output logic       lsb_tail,
    output logic [1:0] chan_pos,
    output logic [1:0] chan_neg,
    output logic       chan_valid
);
    generate
        if (SINGLE_INPUT) begin : g_single
            logic done_q;
            wire  unused_din = din;

            // Purpose: mark setup complete at the first rise of the frame.
            always_ff @(posedge clk) begin
                if (!rst_n)    done_q <= 1'b0;
                else if (cs_n) done_q <= 1'b0;
                else if (rise) done_q <= 1'b1;
            end

            assign take       = ~cs_n & rise & ~done_q;
            assign done       = done_q;
            assign lsb_tail   = 1'b1;
            assign chan_pos   = done_q ? CODE_CH0 : 2'd0;
            assign chan_neg   = done_q ? CODE_CH1 : 2'd0;
            assign chan_valid = done_q;

            p_single_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(done_q) |-> $past(rise));
        end else begin : g_cmd
            cmd_state_e state;
            logic [1:0] fcnt;
            logic       sgl_q, odd_q, msbf_q;

            // Purpose: start search, setup field capture and lockout.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state  <= CMD_HUNT;
                    fcnt   <= 2'd0;
                    sgl_q  <= 1'b0;
                    odd_q  <= 1'b0;
                    msbf_q <= 1'b0;
                end else if (cs_n) begin
                    state <= CMD_HUNT;
                    fcnt  <= 2'd0;
                end else if (rise) begin
                    case (state)
                        CMD_HUNT: if (din) begin
                            state <= CMD_FIELD;
                            fcnt  <= 2'd0;
                        end
                        CMD_FIELD: begin
                            case (fcnt)
                                2'd0:    sgl_q <= din;
                                2'd1:    odd_q <= din;
                                default: begin
                                    msbf_q <= din;
                                    state  <= CMD_DONE;
                                end
                            endcase
                            fcnt <= fcnt + 2'd1;
                        end
                        default: ;
                    endcase
                end
            end

            assign take     = ~cs_n & rise & (state == CMD_FIELD) & (fcnt == 2'd2);
            assign done     = (state == CMD_DONE);
            assign lsb_tail = ~msbf_q;

            // Purpose: map the single-ended and odd/sign flags to a channel pair.
            always_comb begin
                chan_pos   = 2'd0;
                chan_neg   = 2'd0;
                chan_valid = done;
                if (done) begin
                    chan_pos = odd_q ? CODE_CH1 : CODE_CH0;
                    if (sgl_q)      chan_neg = CODE_GND;
                    else if (odd_q) chan_neg = CODE_CH0;
                    else            chan_neg = CODE_CH1;
                end
            end

            p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(cs_n) |-> state == CMD_HUNT);
            p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (state == CMD_DONE && $past(state) == CMD_DONE)
                    |-> ($stable(sgl_q) && $stable(odd_q) && $stable(msbf_q)));
        end
    endgenerate

    p_chan_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chan_valid |-> chan_pos != chan_neg);
endmodule

// File: rtl/adc_emu_shift.sv
// Result sequencer. It holds the captured sample and walks a slot table on
// falling serial clock edges: null bit, MSB-first bits, optional LSB-first
// tail, then zeros.
// Assumes fall is a one-cycle pulse and that done stays high for the frame.
module adc_emu_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              fall,
    input  logic              take,
    input  logic              done,
    input  logic              lsb_tail,
    input  logic [DATA_W-1:0] sample_in,
    output logic              data_q,
    output logic              oe_q
);
    localparam int LAST  = 2 * DATA_W;
    localparam int IDX_W = $clog2(LAST + 1);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);

    logic [DATA_W-1:0] sample_q;
    logic [IDX_W-1:0]  idx;
    logic [DEPTH-1:0]  slot;

    // Slot p holds the bit sent p falls after the null bit.
    generate
        for (genvar p = 0; p < DEPTH; p++) begin : g_slot
            if (p >= 1 && p <= DATA_W) begin : g_msb
                assign slot[p] = sample_q[DATA_W-p];
            end else if (p > DATA_W && p < LAST) begin : g_lsb
                assign slot[p] = lsb_tail & sample_q[p-DATA_W];
            end else begin : g_zero
                assign slot[p] = 1'b0;
            end
        end
    endgenerate

    // Purpose: capture the converter stand-in once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)    sample_q <= '0;
        else if (take) sample_q <= sample_in;
    end

    // Purpose: drive null bit, then step through the slot table on falls.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            oe_q   <= 1'b0;
            data_q <= 1'b0;
            idx    <= '0;
        end else if (fall && done) begin
            if (!oe_q) begin
                oe_q   <= 1'b1;
                data_q <= 1'b0;
                idx    <= IDX_W'(1);
            end else begin
                data_q <= slot[idx];
                idx    <= (idx == LAST_IDX) ? idx : idx + IDX_W'(1);
            end
        end
    end

    p_oe_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(fall));
    p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q |-> !data_q);
    p_sample_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(sample_q));
    p_idx_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);
endmodule

// File: rtl/adc_emu.sv
// Top of the serial ADC port emulator. It joins the edge finder, the command
// receiver and the result sequencer. Chip select gates the serial outputs
// directly, so they drop at once when the host deselects.
// Assumes all inputs are synchronous to clk.
module adc_emu
    import adc_emu_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter bit SINGLE_INPUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [DATA_W-1:0] sample_in,
    output logic              so_data,
    output logic              so_oe,
    output logic [1:0]        chan_pos,
    output logic [1:0]        chan_neg,
    output logic              chan_valid
);
    logic rise, fall, take, done, lsb_tail;
    logic data_q, oe_q;

    adc_emu_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    adc_emu_cmd #(.SINGLE_INPUT(SINGLE_INPUT)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .din        (din),
        .rise       (rise),
        .take       (take),
        .done       (done),
        .lsb_tail   (lsb_tail),
        .chan_pos   (chan_pos),
        .chan_neg   (chan_neg),
        .chan_valid (chan_valid)
    );

    adc_emu_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .fall      (fall),
        .take      (take),
        .done      (done),
        .lsb_tail  (lsb_tail),
        .sample_in (sample_in),
        .data_q    (data_q),
        .oe_q      (oe_q)
    );

    assign so_oe   = oe_q & ~cs_n;
    assign so_data = data_q & ~cs_n;

    p_enable_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> done);
endmodule

// File: tb/test_adc_emu.sv
`timescale 1ns/1ps
module test_adc_emu;
    localparam int HP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       cs_s = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic [7:0] smp = 8'h00;
    logic [7:0] smp_s = 8'h00;
    logic       so_data, so_oe, chan_valid;
    logic [1:0] chan_pos, chan_neg;
    logic       so_data_s, so_oe_s, chan_valid_s;
    logic [1:0] chan_pos_s, chan_neg_s;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    adc_emu #(.DATA_W(8), .SINGLE_INPUT(1'b0)) i_adc_emu (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample_in(smp), .so_data(so_data), .so_oe(so_oe),
        .chan_pos(chan_pos), .chan_neg(chan_neg), .chan_valid(chan_valid)
    );

    adc_emu #(.DATA_W(8), .SINGLE_INPUT(1'b1)) i_adc_emu_single (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_s), .sclk(sclk), .din(din),
        .sample_in(smp_s), .so_data(so_data_s), .so_oe(so_oe_s),
        .chan_pos(chan_pos_s), .chan_neg(chan_neg_s), .chan_valid(chan_valid_s)
    );

    // Vector: {leading zeros[2:0], single, odd, msb-first, sample[7:0], pos[1:0], neg[1:0]}
    localparam logic [17:0] VECS [6] = '{
        {3'd0, 3'b101, 8'hA5, 2'd0, 2'd2},
        {3'd3, 3'b110, 8'h3C, 2'd1, 2'd2},
        {3'd1, 3'b000, 8'h81, 2'd0, 2'd1},
        {3'd2, 3'b011, 8'h7E, 2'd1, 2'd0},
        {3'd0, 3'b100, 8'hFF, 2'd0, 2'd2},
        {3'd5, 3'b010, 8'h00, 2'd1, 2'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sclk_cycle(input logic d);
        din  = d;
        sclk = 1'b1;
        wait_clk(HP);
        sclk = 1'b0;
        wait_clk(HP);
    endtask

    // Expected serial bit at slot p after the null bit.
    function automatic int exp_bit(input int p, input logic [7:0] s, input logic msbf);
        if (p >= 1 && p <= 8) return int'(s[8-p]);
        if (!msbf && p >= 9 && p <= 15) return int'(s[p-8]);
        return 0;
    endfunction

    initial begin
        repeat (40000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check("R10 oe", so_oe, 0);
        check("R10 data", so_data, 0);
        check("R10 valid", chan_valid, 0);

        // Table walk: R1..R7
        foreach (VECS[v]) begin
            logic [2:0] lead;
            logic       sgl, odd, msbf;
            logic [7:0] s;
            logic [1:0] ep, en;
            {lead, sgl, odd, msbf, s, ep, en} = VECS[v];
            smp  = s;
            cs_n = 1'b0;
            wait_clk(2);
            for (int k = 0; k < int'(lead); k++) begin
                sclk_cycle(1'b0);
                check("R1 oe during zeros", so_oe, 0);
                check("R1 valid during zeros", chan_valid, 0);
            end
            sclk_cycle(1'b1);
            check("R1 oe after start", so_oe, 0);
            sclk_cycle(sgl);
            sclk_cycle(odd);
            din  = msbf;
            sclk = 1'b1;
            wait_clk(HP);
            check("R4 oe before fall", so_oe, 0);
            check("R3 valid", chan_valid, 1);
            smp  = ~s;
            sclk = 1'b0;
            wait_clk(HP);
            check("R4 null oe", so_oe, 1);
            check("R4 null data", so_data, 0);
            check("R3 pos", chan_pos, int'(ep));
            check("R3 neg", chan_neg, int'(en));
            for (int p = 1; p <= 18; p++) begin
                sclk_cycle(p[0]);
                check(p <= 8 ? "R5 msb bit" : "R6 tail bit", so_data, exp_bit(p, s, msbf));
            end
            check("R7 oe held", so_oe, 1);
            check("R2 pos locked", chan_pos, int'(ep));
            check("R2 neg locked", chan_neg, int'(en));
            cs_n = 1'b1;
            #1;
            check("R4 oe off", so_oe, 0);
            check("R4 data off", so_data, 0);
            wait_clk(3);
        end

        // R8: abort during command, then a fresh frame
        cs_n = 1'b0;
        wait_clk(2);
        sclk_cycle(1'b1);
        sclk_cycle(1'b1);
        cs_n = 1'b1;
        wait_clk(2);
        check("R8 valid after abort", chan_valid, 0);
        cs_n = 1'b0;
        smp  = 8'hC3;
        wait_clk(2);
        sclk_cycle(1'b0);
        check("R8 no early oe", so_oe, 0);
        sclk_cycle(1'b1);
        sclk_cycle(1'b0);
        sclk_cycle(1'b1);
        sclk_cycle(1'b1);
        check("R8 null oe", so_oe, 1);
        check("R8 pos", chan_pos, 1);
        check("R8 neg", chan_neg, 0);
        sclk_cycle(1'b0);
        check("R8 B7", so_data, 1);
        sclk_cycle(1'b0);
        check("R8 B6", so_data, 1);
        sclk_cycle(1'b0);
        check("R8 B5", so_data, 0);
        sclk_cycle(1'b0);
        sclk_cycle(1'b0);
        sclk_cycle(1'b0);
        check("R8 B2", so_data, 0);
        sclk_cycle(1'b0);
        check("R8 B1", so_data, 1);
        // abort during transfer
        cs_n = 1'b1;
        #1;
        check("R8 oe drop", so_oe, 0);
        check("R8 data drop", so_data, 0);
        wait_clk(2);
        check("R8 valid drop", chan_valid, 0);

        // R10: reset during an active transfer with chip select low
        cs_n = 1'b0;
        smp  = 8'hFF;
        wait_clk(2);
        sclk_cycle(1'b1);
        sclk_cycle(1'b1);
        sclk_cycle(1'b0);
        sclk_cycle(1'b1);
        sclk_cycle(1'b0);
        check("R10 frame active", so_oe, 1);
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        check("R10 oe cleared", so_oe, 0);
        check("R10 valid cleared", chan_valid, 0);
        sclk_cycle(1'b0);
        check("R10 stays quiet", so_oe, 0);
        cs_n = 1'b1;
        wait_clk(3);

        // R9: single-input variant
        smp_s = 8'h96;
        cs_s  = 1'b0;
        wait_clk(2);
        check("R9 quiet before edges", so_oe_s, 0);
        sclk_cycle(1'b0);
        check("R9 null oe", so_oe_s, 1);
        check("R9 null data", so_data_s, 0);
        check("R9 valid", chan_valid_s, 1);
        check("R9 pos", chan_pos_s, 0);
        check("R9 neg", chan_neg_s, 1);
        smp_s = 8'h00;
        for (int p = 1; p <= 17; p++) begin
            sclk_cycle(1'b1);
            check("R9 stream", so_data_s, exp_bit(p, 8'h96, 1'b0));
        end
        cs_s = 1'b1;
        #1;
        check("R9 oe off", so_oe_s, 0);
        wait_clk(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule